// File: doc/BRIEF.md
# 64b/66b Block Encoder with Multiplicative Scrambler

This block turns a stream of 64-bit payload words into 66-bit line blocks. Each cycle it can take one word. A flag on the word says whether it holds only data or a mix of control and data. The block scrambles the 64 payload bits with a self-synchronous scrambler. The feedback polynomial is 1 + x^39 + x^58. The block then places an unscrambled 2-bit sync header in front of the payload and registers the result with a valid strobe.

Because the header is never scrambled and only two header values are legal, every block has at least one bit transition. A receiver can use that transition to find the block boundary. The receiver runs the matching descrambler on the payload and needs no shared state. After 58 received bits its history matches the encoder's history on its own.

An active-high bypass input sends the payload through unscrambled, for test. The block does not build the control-character fields inside a control block. It also does not serialize the blocks or convert their width.

Top module: `blk66_encoder`

## Requirements
- R1: `out_block[1:0]` carries the sync header. `out_block[65:2]` carries the payload, with payload bit i at `out_block[i+2]`.
- R2: When the input flag `in_ctrl` is 0 (all data), the header field `out_block[1:0]` is 2'b01, meaning bit 0 = 1 and bit 1 = 0.
- R3: When `in_ctrl` is 1 (control and data mixed), the header field `out_block[1:0]` is 2'b10, meaning bit 0 = 0 and bit 1 = 1.
- R4: While `out_valid` is high, the header field is never 2'b00 or 2'b11.
- R5: Payload bits are scrambled one at a time, from bit 0 up to bit 63. Scrambled bit i equals the input bit i XOR the scrambled bit 39 positions earlier XOR the scrambled bit 58 positions earlier.
- R6: The scrambler history holds the last 58 scrambled bits. It carries across blocks and across idle cycles, and it changes only on a valid, non-bypassed word. A matching descrambler therefore recovers every payload.
- R7: Reset is synchronous and active high. It clears `out_valid` and `out_block` to 0. It also loads the history with the nonzero parameter `SEED`, where `SEED[k]` is the scrambled bit k+1 positions before the first bit after reset.
- R8: When `bypass` is 1 on a valid word, the payload appears unscrambled, the header is still chosen as in R2 and R3, and the history is left unchanged.
- R9: `out_valid` equals `in_valid` delayed by exactly one clock.
- R10: When `in_valid` is 0, `out_block` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_ctrl | input | 1 | 1 = word mixes control and data, 0 = all data |
| in_payload | input | 64 | Payload word; bit 0 is scrambled first |
| bypass | input | 1 | 1 = send the payload unscrambled |
| out_valid | output | 1 | Output block valid, one cycle after `in_valid` |
| out_block | output | 66 | Header in [1:0], payload in [65:2] |

## Verification
A corrupted scrambler history cannot be seen on an idle cycle. It shows up as wrong payload bits in the very next valid, non-bypassed block, one clock after the word enters. It then stays wrong for every later block until reset, because the history feeds back on itself. A bad header choice or a broken valid pipeline shows up on the same one-clock boundary. A far-end descrambler in the bench recovers the original payload only if the header position, the bit order and the taps are all correct.

// File: rtl/blk66_pkg.sv
package blk66_pkg;

  typedef enum logic [1:0] {
    HDR_DATA = 2'b01,
    HDR_CTRL = 2'b10
  } sync_hdr_e;

  function automatic sync_hdr_e pick_hdr(input logic is_ctrl);
    return is_ctrl ? HDR_CTRL : HDR_DATA;
  endfunction

endpackage

// File: rtl/blk66_scr_core.sv
module blk66_scr_core #(
  parameter int PAY_W = 64,
  parameter int TAP_A = 39,
  parameter int TAP_B = 58,
  parameter logic [TAP_B-1:0] SEED = 58'h1_2345_6789_ABCD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [PAY_W-1:0] din,
  output logic [PAY_W-1:0] dout
);
  localparam int HIST_W = TAP_B;

  // hist_q[k] is the scrambled bit k+1 positions back
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_work;
  logic              sbit;

  always_comb begin
    hist_work = hist_q;
    dout      = '0;
    sbit      = 1'b0;
    for (int i = 0; i < PAY_W; i++) begin
      sbit      = din[i] ^ hist_work[TAP_A-1] ^ hist_work[TAP_B-1];
      dout[i]   = sbit;
      hist_work = {hist_work[HIST_W-2:0], sbit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= SEED;
    end else if (advance) begin
      hist_q <= hist_work;
    end
  end

endmodule

// File: rtl/blk66_out_stage.sv
module blk66_out_stage
  import blk66_pkg::*;
#(
  parameter int PAY_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  sync_hdr_e        hdr,
  input  logic             bypass,
  input  logic [PAY_W-1:0] raw_pay,
  input  logic [PAY_W-1:0] scr_pay,
  output logic             out_valid,
  output logic [PAY_W+1:0] out_block
);
  localparam int BLK_W = PAY_W + 2;

  logic [PAY_W-1:0] pay_sel;
  logic [BLK_W-1:0] blk_next;

  always_comb begin
    pay_sel  = bypass ? raw_pay : scr_pay;
    blk_next = {pay_sel, logic'(hdr[1]), logic'(hdr[0])};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_block <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_block <= blk_next;
      end
    end
  end

endmodule

// File: rtl/blk66_encoder.sv
module blk66_encoder
  import blk66_pkg::*;
#(
  parameter int PAY_W = 64,
  parameter int TAP_A = 39,
  parameter int TAP_B = 58,
  parameter logic [TAP_B-1:0] SEED = 58'h1_2345_6789_ABCD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_ctrl,
  input  logic [PAY_W-1:0] in_payload,
  input  logic             bypass,
  output logic             out_valid,
  output logic [PAY_W+1:0] out_block
);
  sync_hdr_e        hdr;
  logic [PAY_W-1:0] scr_pay;
  logic             scr_adv;

  assign hdr     = pick_hdr(in_ctrl);
  assign scr_adv = in_valid & ~bypass;

  blk66_scr_core #(
    .PAY_W(PAY_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .SEED(SEED)
  ) u_scr (
    .clk(clk), .rst(rst), .advance(scr_adv), .din(in_payload), .dout(scr_pay)
  );

  blk66_out_stage #(.PAY_W(PAY_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .hdr(hdr), .bypass(bypass),
    .raw_pay(in_payload), .scr_pay(scr_pay),
    .out_valid(out_valid), .out_block(out_block)
  );

endmodule

// File: rtl/blk66_encoder_chk.sv
module blk66_encoder_chk #(
  parameter int PAY_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ctrl,
  input logic [PAY_W-1:0] in_payload,
  input logic             bypass,
  input logic             out_valid,
  input logic [PAY_W+1:0] out_block
);
  localparam int BLK_W = PAY_W + 2;

  assert_hdr_legal_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_block[1:0] == 2'b01 || out_block[1:0] == 2'b10));

  assert_hdr_data_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ctrl) |=> (out_block[1:0] == 2'b01));

  assert_hdr_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ctrl) |=> (out_block[1:0] == 2'b10));

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_bypass_raw_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bypass) |=> (out_block[BLK_W-1:2] == $past(in_payload)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_block));

endmodule

bind blk66_encoder blk66_encoder_chk #(.PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctrl(in_ctrl),
  .in_payload(in_payload), .bypass(bypass),
  .out_valid(out_valid), .out_block(out_block)
);

// File: tb/blk66_encoder_test.sv
`timescale 1ns/1ps
module blk66_encoder_test;
  localparam logic [57:0] SEED = 58'h2_9C3A_F00D_5E71;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ctrl = 1'b0;
  logic [63:0] in_payload = '0;
  logic        bypass = 1'b0;
  logic        out_valid;
  logic [65:0] out_block;

  int n_cmp = 0;
  int n_bad = 0;

  logic        tx_q[$];
  logic        rx_q[$];
  logic        exp_valid;
  logic [65:0] exp_block;

  always #5 clk = ~clk;

  blk66_encoder #(.SEED(SEED)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .in_payload(in_payload), .bypass(bypass),
    .out_valid(out_valid), .out_block(out_block)
  );

  task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic seed_hist(ref logic q[$]);
    q.delete();
    for (int k = 57; k >= 0; k--) q.push_back(SEED[k]);
  endtask

  // Reference: a bit history; the element 39 or 58 back feeds each new bit.
  function automatic logic [63:0] model_scramble(input logic [63:0] p);
    logic [63:0] r;
    logic b;
    for (int i = 0; i < 64; i++) begin
      b = p[i] ^ tx_q[tx_q.size()-39] ^ tx_q[tx_q.size()-58];
      r[i] = b;
      tx_q.push_back(b);
      void'(tx_q.pop_front());
    end
    return r;
  endfunction

  // Far-end descrambler, fed only by the line bits.
  function automatic logic [63:0] far_descramble(input logic [63:0] s);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      r[i] = s[i] ^ rx_q[rx_q.size()-39] ^ rx_q[rx_q.size()-58];
      rx_q.push_back(s[i]);
      void'(rx_q.pop_front());
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; bypass = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R7 reset out_valid", {65'b0, out_valid}, 66'd0);
    check(out_block == '0, "R7 reset out_block", out_block, 66'd0);
    @(negedge clk);
    rst = 1'b0;
    seed_hist(tx_q);
    seed_hist(rx_q);
    exp_valid = 1'b0;
    exp_block = '0;
  endtask

  task automatic cycle(input logic v, input logic c, input logic [63:0] p, input logic b);
    @(negedge clk);
    in_valid = v; in_ctrl = c; in_payload = p; bypass = b;
    exp_valid = v;
    if (v) begin
      exp_block[1:0]  = c ? 2'b10 : 2'b01;
      exp_block[65:2] = b ? p : model_scramble(p);
    end
    @(posedge clk);
    #1;
    check(out_valid == exp_valid, "R9 valid latency", {65'b0, out_valid}, {65'b0, exp_valid});
    if (v) begin
      check(out_block[1:0] == exp_block[1:0], c ? "R3 ctrl header" : "R2 data header",
            {64'b0, out_block[1:0]}, {64'b0, exp_block[1:0]});
      check(out_block[1:0] == 2'b01 || out_block[1:0] == 2'b10, "R4 legal header",
            {64'b0, out_block[1:0]}, {64'b0, exp_block[1:0]});
      check(out_block[65:2] == exp_block[65:2], b ? "R8 bypass payload" : "R5 R1 scrambled payload",
            out_block, exp_block);
      if (!b) begin
        logic [63:0] rec;
        rec = far_descramble(out_block[65:2]);
        check(rec == p, "R6 far-end recovery", {2'b0, rec}, {2'b0, p});
      end
    end else begin
      check(out_block == exp_block, "R10 idle hold", out_block, exp_block);
    end
  endtask

  initial begin
    logic [63:0] first_out;
    do_reset();
    // R7: all-zero word exposes the seed directly
    cycle(1'b1, 1'b0, 64'h0, 1'b0);
    first_out = out_block[65:2];
    cycle(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    cycle(1'b1, 1'b1, 64'hAAAA_5555_AAAA_5555, 1'b0);
    cycle(1'b1, 1'b0, 64'h0000_0000_0000_0001, 1'b0);
    cycle(1'b1, 1'b1, 64'h8000_0000_0000_0000, 1'b0);
    // R10 / R6: idle gaps keep history and block
    cycle(1'b0, 1'b1, 64'hDEAD_BEEF_0000_1111, 1'b0);
    cycle(1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 1'b1);
    cycle(1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b0);
    // R8: bypass blocks leave history untouched
    cycle(1'b1, 1'b0, 64'hCAFE_F00D_1234_5678, 1'b1);
    cycle(1'b1, 1'b1, 64'h0F0F_0F0F_F0F0_F0F0, 1'b1);
    cycle(1'b1, 1'b0, 64'h0, 1'b0);
    // walking one
    for (int i = 0; i < 64; i++) cycle(1'b1, i[0], 64'h1 << i, 1'b0);
    // pseudo-random mix
    for (int i = 0; i < 200; i++) begin
      logic [63:0] w;
      w = {$urandom(), $urandom()};
      cycle(($urandom() % 4) != 0, $urandom() % 2, w, ($urandom() % 8) == 0);
    end
    // R7: reset mid-stream restarts from the seed
    do_reset();
    cycle(1'b1, 1'b0, 64'h0, 1'b0);
    check(out_block[65:2] == first_out, "R7 seed reload", {2'b0, out_block[65:2]}, {2'b0, first_out});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule